// File: doc/BRIEF.md
# UART FIFO Interrupt Request Generator

This block produces the receive, transmit, error and receive-timeout interrupt requests for a UART with receive and transmit FIFOs. It watches the occupancy counts that the FIFOs report and compares them with programmable thresholds. It also watches the character strobe and the read strobe of the receive FIFO, and the per-character error flags that the deserializer delivers with each received character. The FIFOs, the serializer and deserializer, and the baud generator are separate blocks.

In FIFO mode the receive request rises once the receive count reaches its threshold. The transmit request rises once the transmit count falls to its threshold. A timeout request covers the case where a few characters sit in the receive FIFO below the threshold and the line then goes quiet for three character times. The length of one character time follows the programmed frame format. In single-register mode the requests follow the holding registers: receive when one is full, transmit when one is empty. Error causes are captured in sticky flags. The flags drive one level request until software acknowledges it. Each source has its own mask bit, and all requests are registered, active-high levels.

Top module: `uart_irq_gen`

## Requirements
- R1: With `fifo_en_i`=1, `rx_irq_o` is 1 one clock after `rx_count_i >= rx_trig_i`, and 0 one clock after the count is below the threshold.
- R2: With `fifo_en_i`=1, `tx_irq_o` is 1 one clock after `tx_count_i <= tx_trig_i`, and 0 otherwise.
- R3: With `fifo_en_i`=0, `rx_irq_o` follows `rx_count_i != 0` and `tx_irq_o` follows `tx_count_i == 0`, each one clock later.
- R4: The timeout is armed when `fifo_en_i`=1 and `0 < rx_count_i < rx_trig_i`. It counts only cycles with `baud_tick_i`=1. `tmo_o` rises one clock after the tick count reaches 3*16*B. The count does not advance while `baud_tick_i`=0.
- R5: In R4, the character length B = 1 start + (5 + `data_bits_i`) data + `parity_en_i` + 1 stop + `two_stop_i`. The encoding of `data_bits_i` is 0..3 for 5..8 data bits, so B ranges from 7 to 12.
- R6: A pulse on `rx_push_i` or `rx_pop_i` restarts the timeout count from zero and drops `tmo_o`. An empty receive FIFO, a count at or above the threshold, or `fifo_en_i`=0 disarms the timeout and holds `tmo_o` at 0.
- R7: The frame, parity and break inputs are captured only on a cycle with `rx_push_i`=1. They go into sticky bits of `err_flags_o`: bit 0 frame, bit 1 parity, bit 2 break. Error inputs on a cycle without a push are ignored.
- R8: A push while the receive FIFO is full sets overrun, which is bit 3 of `err_flags_o`. The FIFO counts as full when `rx_count_i == DEPTH` in FIFO mode, and when `rx_count_i != 0` in single-register mode.
- R9: `err_irq_o` is a single level for any nonzero set of flags, whether one cause or several arrived together. The flags and `err_irq_o` hold until an `err_ack_i` pulse clears them one clock later. If an acknowledge and a new error arrive in the same cycle, the new causes remain set.
- R10: `mask_i` bit 0 masks rx, bit 1 masks tx, bit 2 masks err and bit 3 masks tmo. A value of 1 forces the request low one clock later. Masking does not stop flag capture or the timeout count.
- R11: While `rst_ni`=0, all request outputs and `err_flags_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = FIFO mode, 0 = single holding register |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| rx_trig_i | input | CNT_W | Receive threshold |
| tx_trig_i | input | CNT_W | Transmit threshold |
| data_bits_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Parity bit present |
| two_stop_i | input | 1 | Second stop bit present |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| rx_push_i | input | 1 | Received character strobe |
| rx_pop_i | input | 1 | Receive FIFO read strobe |
| frame_err_i | input | 1 | Frame error of pushed character |
| parity_err_i | input | 1 | Parity error of pushed character |
| break_i | input | 1 | Break seen with pushed character |
| err_ack_i | input | 1 | Clears error flags |
| mask_i | input | 4 | Per-source mask, 1 = suppressed |
| rx_irq_o | output | 1 | Receive request |
| tx_irq_o | output | 1 | Transmit request |
| err_irq_o | output | 1 | Error request |
| tmo_o | output | 1 | Receive timeout request |
| err_flags_o | output | 4 | Sticky causes {overrun, break, parity, frame} |

## Verification
A wrong comparison or mode select shows on `rx_irq_o` or `tx_irq_o` one clock after the count crosses its threshold. A timeout counter that restarts wrongly, uses a wrong character length or counts without ticks moves the `tmo_o` edge away from 3*16*B ticks, which is checked at that exact cycle and the one before. Lost or stale sticky state shows on `err_flags_o` one clock after a push or an acknowledge, before the next stimulus.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IRQ_RX  = 0;
  localparam int unsigned IRQ_TX  = 1;
  localparam int unsigned IRQ_ERR = 2;
  localparam int unsigned IRQ_TMO = 3;
  localparam int unsigned MAX_CHAR_BITS = 12;

  typedef struct packed {
    logic ovr;
    logic brk;
    logic par;
    logic frm;
  } err_flags_t;

  // start + data(5..8) + parity + stop(1..2)
  function automatic logic [3:0] char_bits(logic [1:0] dbits, logic par, logic two_stop);
    return 4'd7 + {2'b00, dbits} + {3'b000, par} + {3'b000, two_stop};
  endfunction
endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             rx_full_o,
  output logic             tmo_arm_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic rx_nonempty;
  assign rx_nonempty = (rx_count_i != '0);

  always_comb begin
    if (fifo_en_i) begin
      rx_req_o  = (rx_count_i >= rx_trig_i);
      tx_req_o  = (tx_count_i <= tx_trig_i);
      rx_full_o = (rx_count_i == FULL_CNT);
    end else begin
      rx_req_o  = rx_nonempty;
      tx_req_o  = (tx_count_i == '0);
      rx_full_o = rx_nonempty;
    end
  end

  assign tmo_arm_o = fifo_en_i && rx_nonempty && (rx_count_i < rx_trig_i);
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
  import uart_irq_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned WORDS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic [1:0] data_bits_i,
  input  logic       parity_en_i,
  input  logic       two_stop_i,
  output logic       hit_o
);
  localparam int unsigned MAX_TICKS = WORDS * OVS * MAX_CHAR_BITS;
  localparam int unsigned TW        = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] limit;
  logic [3:0]    bits;
  logic          at_limit;

  assign bits     = char_bits(data_bits_i, parity_en_i, two_stop_i);
  assign limit    = TW'(WORDS * OVS) * TW'(bits);
  assign at_limit = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!arm_i || restart_i) begin
      cnt_q <= '0;
    end else if (tick_i && !at_limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = arm_i && !restart_i && at_limit;
endmodule

// File: rtl/uart_irq_err.sv
module uart_irq_err
  import uart_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       full_i,
  input  logic       frm_i,
  input  logic       par_i,
  input  logic       brk_i,
  input  logic       ack_i,
  output err_flags_t flags_o,
  output err_flags_t flags_nxt_o
);
  err_flags_t flags_q;
  err_flags_t fresh;

  always_comb begin
    fresh.frm = push_i && frm_i;
    fresh.par = push_i && par_i;
    fresh.brk = push_i && brk_i;
    fresh.ovr = push_i && full_i;
    flags_nxt_o = (ack_i ? err_flags_t'('0) : flags_q) | fresh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_nxt_o;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OVS   = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  input  logic             baud_tick_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             frame_err_i,
  input  logic             parity_err_i,
  input  logic             break_i,
  input  logic             err_ack_i,
  input  logic [3:0]       mask_i,
  output logic             rx_irq_o,
  output logic             tx_irq_o,
  output logic             err_irq_o,
  output logic             tmo_o,
  output logic [3:0]       err_flags_o
);
  logic rx_req, tx_req, rx_full, tmo_arm, tmo_hit;
  err_flags_t flags_q, flags_nxt;

  uart_irq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .fifo_en_i (fifo_en_i),
    .rx_count_i(rx_count_i),
    .tx_count_i(tx_count_i),
    .rx_trig_i (rx_trig_i),
    .tx_trig_i (tx_trig_i),
    .rx_req_o  (rx_req),
    .tx_req_o  (tx_req),
    .rx_full_o (rx_full),
    .tmo_arm_o (tmo_arm)
  );

  uart_irq_timeout #(.OVS(OVS), .WORDS(3)) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (tmo_arm),
    .restart_i  (rx_push_i || rx_pop_i),
    .tick_i     (baud_tick_i),
    .data_bits_i(data_bits_i),
    .parity_en_i(parity_en_i),
    .two_stop_i (two_stop_i),
    .hit_o      (tmo_hit)
  );

  uart_irq_err u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_push_i),
    .full_i     (rx_full),
    .frm_i      (frame_err_i),
    .par_i      (parity_err_i),
    .brk_i      (break_i),
    .ack_i      (err_ack_i),
    .flags_o    (flags_q),
    .flags_nxt_o(flags_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_irq_o  <= 1'b0;
      tx_irq_o  <= 1'b0;
      err_irq_o <= 1'b0;
      tmo_o     <= 1'b0;
    end else begin
      rx_irq_o  <= rx_req  && !mask_i[IRQ_RX];
      tx_irq_o  <= tx_req  && !mask_i[IRQ_TX];
      err_irq_o <= (|flags_nxt) && !mask_i[IRQ_ERR];
      tmo_o     <= tmo_hit && !mask_i[IRQ_TMO];
    end
  end

  assign err_flags_o = flags_q;
endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [CNT_W-1:0] tx_count_i,
  input logic [CNT_W-1:0] rx_trig_i,
  input logic [CNT_W-1:0] tx_trig_i,
  input logic             rx_push_i,
  input logic             rx_pop_i,
  input logic             err_ack_i,
  input logic [3:0]       mask_i,
  input logic             rx_irq_o,
  input logic             tx_irq_o,
  input logic             err_irq_o,
  input logic             tmo_o,
  input logic [3:0]       err_flags_o
);
  AST_RX_FIFO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rx_count_i >= rx_trig_i && !mask_i[0]) |=> rx_irq_o); // R1
  AST_TX_FIFO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && tx_count_i > tx_trig_i) |=> !tx_irq_o); // R2
  AST_RX_SINGLE_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && rx_count_i == '0) |=> !rx_irq_o); // R3
  AST_TMO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i || rx_pop_i) |=> !tmo_o); // R6
  AST_TMO_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i || rx_count_i == '0 || rx_count_i >= rx_trig_i) |=> !tmo_o); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && fifo_en_i && rx_count_i == CNT_W'(DEPTH)) |=> err_flags_o[3]); // R8
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flags_o != 4'd0 && !err_ack_i) |=> (err_flags_o != 4'd0)); // R9
  AST_ERR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i[2] |=> !err_irq_o); // R10
  AST_ERR_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_i[2] && !err_ack_i && err_flags_o != 4'd0) |=> err_irq_o); // R9
endmodule

bind uart_irq_gen uart_irq_gen_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_irq_gen_test.sv
`timescale 1ns/1ps
module uart_irq_gen_test;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_en_i = 1'b1;
  logic [CNT_W-1:0] rx_count_i = '0, tx_count_i = CNT_W'(8);
  logic [CNT_W-1:0] rx_trig_i = CNT_W'(8), tx_trig_i = CNT_W'(4);
  logic [1:0] data_bits_i = 2'd3;
  logic parity_en_i = 1'b0, two_stop_i = 1'b0, baud_tick_i = 1'b0;
  logic rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic frame_err_i = 1'b0, parity_err_i = 1'b0, break_i = 1'b0, err_ack_i = 1'b0;
  logic [3:0] mask_i = 4'd0;
  logic rx_irq_o, tx_irq_o, err_irq_o, tmo_o;
  logic [3:0] err_flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  uart_irq_gen #(.DEPTH(DEPTH), .OVS(16)) uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    chk("R11 rx", rx_irq_o, 0);
    chk("R11 tx", tx_irq_o, 0);
    chk("R11 err", err_irq_o, 0);
    chk("R11 tmo", tmo_o, 0);
    chk("R11 flags", err_flags_o, 0);
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_fifo_levels();
    fifo_en_i = 1'b1; rx_trig_i = 8;
    rx_count_i = 7; step(); chk("R1 below", rx_irq_o, 0);
    rx_count_i = 8; step(); chk("R1 equal", rx_irq_o, 1);
    rx_count_i = 16; step(); chk("R1 above", rx_irq_o, 1);
    rx_trig_i = 0; rx_count_i = 0; step(); chk("R1 zero trig", rx_irq_o, 1);
    rx_trig_i = 8;
    tx_trig_i = 4;
    tx_count_i = 5; step(); chk("R2 above", tx_irq_o, 0);
    tx_count_i = 4; step(); chk("R2 equal", tx_irq_o, 1);
    tx_count_i = 0; step(); chk("R2 empty", tx_irq_o, 1);
    tx_count_i = 8; rx_count_i = 0; step();
  endtask

  task automatic t_single_reg();
    fifo_en_i = 1'b0;
    rx_count_i = 0; tx_count_i = 1; step();
    chk("R3 rx empty", rx_irq_o, 0);
    chk("R3 tx full", tx_irq_o, 0);
    rx_count_i = 1; tx_count_i = 0; step();
    chk("R3 rx full", rx_irq_o, 1);
    chk("R3 tx empty", tx_irq_o, 1);
    rx_count_i = 0; tx_count_i = 8; fifo_en_i = 1'b1; step();
  endtask

  task automatic t_timeout(logic [1:0] d, logic p, logic s);
    int unsigned lim;
    lim = 48 * (1 + 5 + d + p + 1 + s);
    data_bits_i = d; parity_en_i = p; two_stop_i = s;
    fifo_en_i = 1'b1; rx_trig_i = 8; rx_count_i = 3; baud_tick_i = 1'b1;
    rx_pop_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rx_pop_i = 1'b0;
    repeat (lim) @(posedge clk_i);
    @(negedge clk_i);
    chk($sformatf("R4 R5 early d=%0d p=%0d s=%0d", d, p, s), tmo_o, 0);
    step();
    chk($sformatf("R4 R5 fire d=%0d p=%0d s=%0d", d, p, s), tmo_o, 1);
    step();
    chk("R4 held", tmo_o, 1);
  endtask

  task automatic t_timeout_restart();
    int unsigned lim;
    data_bits_i = 3; parity_en_i = 0; two_stop_i = 0;
    lim = 480;
    rx_count_i = 3; baud_tick_i = 1'b1;
    rx_pop_i = 1'b1; step(); rx_pop_i = 1'b0;
    chk("R6 pop drops", tmo_o, 0);
    repeat (lim - 5) step();
    rx_push_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    rx_push_i = 1'b0;
    repeat (lim) @(posedge clk_i);
    @(negedge clk_i);
    chk("R6 push restart early", tmo_o, 0);
    step();
    chk("R6 push restart fire", tmo_o, 1);
    rx_count_i = 0; step();
    chk("R6 empty disarm", tmo_o, 0);
    rx_count_i = 8; repeat (lim + 4) step();
    chk("R6 at trigger disarm", tmo_o, 0);
    // ticks held low: no progress
    rx_count_i = 3; baud_tick_i = 1'b0;
    rx_pop_i = 1'b1; step(); rx_pop_i = 1'b0;
    repeat (lim + 20) step();
    chk("R4 no ticks", tmo_o, 0);
    rx_count_i = 0; step();
  endtask

  task automatic t_errors();
    mask_i = 4'd0; fifo_en_i = 1'b1; rx_count_i = 2;
    frame_err_i = 1; parity_err_i = 1; break_i = 1; step();
    chk("R7 no push ignored", err_flags_o, 0);
    chk("R7 no push irq", err_irq_o, 0);
    rx_push_i = 1; step();
    rx_push_i = 0; frame_err_i = 0; parity_err_i = 0; break_i = 0;
    chk("R7 flags", err_flags_o, 4'b0111);
    chk("R9 single level", err_irq_o, 1);
    step();
    chk("R9 held", err_irq_o, 1);
    err_ack_i = 1; step(); err_ack_i = 0;
    chk("R9 ack flags", err_flags_o, 0);
    chk("R9 ack irq", err_irq_o, 0);
    rx_push_i = 1; parity_err_i = 1; step();
    rx_push_i = 0; parity_err_i = 0;
    chk("R7 parity only", err_flags_o, 4'b0010);
    err_ack_i = 1; rx_push_i = 1; frame_err_i = 1; step();
    err_ack_i = 0; rx_push_i = 0; frame_err_i = 0;
    chk("R9 ack with new", err_flags_o, 4'b0001);
    chk("R9 ack with new irq", err_irq_o, 1);
    err_ack_i = 1; step(); err_ack_i = 0;
  endtask

  task automatic t_overrun();
    fifo_en_i = 1'b1; rx_count_i = 15; rx_push_i = 1; step(); rx_push_i = 0;
    chk("R8 not full", err_flags_o, 0);
    rx_count_i = 16; rx_push_i = 1; step(); rx_push_i = 0;
    chk("R8 fifo full", err_flags_o, 4'b1000);
    err_ack_i = 1; step(); err_ack_i = 0;
    fifo_en_i = 1'b0; rx_count_i = 0; rx_push_i = 1; step(); rx_push_i = 0;
    chk("R8 holding empty", err_flags_o, 0);
    rx_count_i = 1; rx_push_i = 1; step(); rx_push_i = 0;
    chk("R8 holding full", err_flags_o, 4'b1000);
    err_ack_i = 1; step(); err_ack_i = 0;
    fifo_en_i = 1'b1; rx_count_i = 0; step();
  endtask

  task automatic t_mask();
    fifo_en_i = 1'b1; rx_trig_i = 8; rx_count_i = 10; tx_count_i = 0;
    mask_i = 4'b0011; step();
    chk("R10 rx masked", rx_irq_o, 0);
    chk("R10 tx masked", tx_irq_o, 0);
    mask_i = 4'b0100; rx_push_i = 1; break_i = 1; step();
    rx_push_i = 0; break_i = 0;
    chk("R10 flag captured", err_flags_o, 4'b0100);
    chk("R10 err masked", err_irq_o, 0);
    chk("R10 rx unmasked", rx_irq_o, 1);
    mask_i = 4'b0000; step();
    chk("R10 err unmasked", err_irq_o, 1);
    err_ack_i = 1; step(); err_ack_i = 0;
    // masked timeout keeps counting
    rx_count_i = 3; tx_count_i = 8; baud_tick_i = 1; data_bits_i = 0;
    parity_en_i = 0; two_stop_i = 0; mask_i = 4'b1000;
    rx_pop_i = 1; step(); rx_pop_i = 0;
    repeat (340) step();
    chk("R10 tmo masked", tmo_o, 0);
    mask_i = 4'b0000; step();
    chk("R10 tmo unmasked", tmo_o, 1);
  endtask

  initial begin
    t_reset();
    t_fifo_levels();
    t_single_reg();
    t_timeout(2'd0, 1'b0, 1'b0);
    t_timeout(2'd3, 1'b1, 1'b1);
    t_timeout(2'd1, 1'b1, 1'b0);
    t_timeout_restart();
    t_errors();
    t_overrun();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule